// File: doc/BRIEF.md
# Key-Locked Boot Vector Register Bank

This block is a small configuration bank on a plain memory-mapped bus. It holds the reset vector for a secondary processor core, and it drives that vector to the core's reset logic. The vector register is write-protected. Software unlocks it by storing two fixed 32-bit keys, one into each of two key registers. The vector is kept only to a 1 KB boundary: its ten lowest address bits are always zero.

The intended use follows every device, system or warm reset. Boot software writes both keys, programs the vector and then releases the secondary core through other logic. Any wrong key value closes the bank again. A status output reports whether the bank is locked. Later clock gating of the secondary core does not involve this block.

Register map, by word index on `regAddr`:
- 0: key register A.
- 1: key register B.
- 2: boot vector.
- 3 to 7: unmapped.

Top module: `boot_vec_bank`

## Requirements
- R1: After reset, `locked` is 1 and `bootAddr` is 0.
- R2: While `locked` is 1, a write to index 2 leaves `bootAddr` unchanged. Index 2 always reads back the current vector on `rdData`.
- R3: The bank unlocks after 32'h83E70B13 is written to index 0 and 32'h95A4F1E0 is written to index 1, in either order. `locked` drops to 0 the cycle after the second correct key write.
- R4: Writing any other value to index 0 or index 1 sets `locked` to 1 in the next cycle. It also discards the progress of both keys, so both must be written again.
- R5: A write to index 2 while unlocked updates `bootAddr` the next cycle. Only `wrData[31:10]` is stored. Bits 9:0 of `bootAddr` and of the read-back value are always 0.
- R6: Indices 0, 1 and 3 to 7 read as 0. A write to indices 3 to 7 changes neither `locked` nor `bootAddr`.
- R7: Once unlocked, the bank stays unlocked across vector writes, repeated correct key writes and unmapped writes, until a wrong key write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Word index of the accessed register |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| bootAddr | output | 32 | Boot address for the secondary core, low 10 bits zero |
| locked | output | 1 | 1 while the vector register is write-protected |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- **Key order.** It unlocks with the keys in both orders. A design that demanded a fixed order would stay locked.
- **Wrong key after one correct key.** It writes one correct key, then a wrong value to the other register, and checks that a single correct key no longer unlocks. A design that cleared only the targeted key would unlock early.
- **Low-bit zero forcing.** It writes all-ones vectors and checks that the low ten bits read as zero. A design storing full words would show nonzero low bits.
- **Ignored writes.** It mixes writes to the locked vector and to unmapped indices with random traffic. A leaky write gate would corrupt the vector a model tracks.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;

  // Word indices of the register map
  localparam int IDX_KEY_A = 0;
  localparam int IDX_KEY_B = 1;
  localparam int IDX_VEC   = 2;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_VEC  = 2'd1
  } rdSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   vecWe;
    rdSel_t rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/boot_vec_ctrl.sv
module boot_vec_ctrl
  import boot_vec_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY_B = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output bankStrobe_t       strobe,
  output logic              locked
);

  logic selKeyA, selKeyB, selVec;
  logic keyAOk, keyBOk;
  logic goodA, goodB, badKey;

  // Address decode
  always_comb begin
    selKeyA = (regAddr == ADDR_W'(IDX_KEY_A));
    selKeyB = (regAddr == ADDR_W'(IDX_KEY_B));
    selVec  = (regAddr == ADDR_W'(IDX_VEC));
  end

  // Key comparison
  always_comb begin
    goodA  = wrEn && selKeyA && (wrData == KEY_A);
    goodB  = wrEn && selKeyB && (wrData == KEY_B);
    badKey = wrEn && ((selKeyA && (wrData != KEY_A)) ||
                      (selKeyB && (wrData != KEY_B)));
  end

  // Key progress flags: a bad key clears both
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyAOk <= 1'b0;
      keyBOk <= 1'b0;
    end else if (badKey) begin
      keyAOk <= 1'b0;
      keyBOk <= 1'b0;
    end else begin
      if (goodA) keyAOk <= 1'b1;
      if (goodB) keyBOk <= 1'b1;
    end
  end

  assign locked = !(keyAOk && keyBOk);

  always_comb begin
    strobe.vecWe = wrEn && selVec && !locked;
    strobe.rdSel = selVec ? RD_VEC : RD_ZERO;
  end

  AST_RELOCK_BAD_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ((selKeyA && wrData != KEY_A) || (selKeyB && wrData != KEY_B))) |=> locked); // R4

  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(wrEn) && ($past(selKeyA) || $past(selKeyB)))); // R3

  AST_STAY_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !(wrEn && (selKeyA || selKeyB))) |=> !locked); // R7

endmodule

// File: rtl/boot_vec_dp.sv
module boot_vec_dp
  import boot_vec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 10,
  localparam int HI_W      = DATA_W - ALIGN_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  bankStrobe_t     strobe,
  input  logic [HI_W-1:0] wrHi,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] bootAddr
);

  logic [HI_W-1:0] vecHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             vecHi <= '0;
    else if (strobe.vecWe) vecHi <= wrHi;
  end

  assign bootAddr = {vecHi, {ALIGN_BITS{1'b0}}};

  always_comb begin
    case (strobe.rdSel)
      RD_VEC:  rdData = bootAddr;
      default: rdData = '0;
    endcase
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.vecWe |=> $stable(vecHi)); // R2

  AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.vecWe |=> (vecHi == $past(wrHi))); // R5

endmodule

// File: rtl/boot_vec_bank.sv
module boot_vec_bank
  import boot_vec_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 10,
  parameter logic [DATA_W-1:0] KEY_A = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY_B = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] bootAddr,
  output logic              locked
);

  localparam int HI_W = DATA_W - ALIGN_BITS;

  bankStrobe_t strobe;

  boot_vec_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .strobe(strobe), .locked(locked)
  );

  boot_vec_dp #(
    .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrHi(wrData[DATA_W-1:ALIGN_BITS]),
    .rdData(rdData), .bootAddr(bootAddr)
  );

  AST_RESET_LOCKED: assert property (@(posedge clk)
    !rstN |=> (locked || !rstN)); // R1

endmodule

// File: tb/tb_boot_vec_bank.sv
`timescale 1ns/1ps
module tb_boot_vec_bank;

  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, bootAddr;
  logic locked;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // Bench model
  bit mA, mB;
  logic [31:0] mVec;

  always #4 clk = ~clk;

  boot_vec_bank dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .bootAddr(bootAddr), .locked(locked)
  );

  function automatic logic [31:0] expRead(logic [2:0] a);
    return (a == 3'd2) ? mVec : 32'h0;
  endfunction

  function automatic bit expLocked();
    return !(mA && mB);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelWrite(logic [2:0] a, logic [31:0] d);
    bit wasLocked = expLocked();
    if (a == 3'd0) begin
      if (d == KA) mA = 1; else begin mA = 0; mB = 0; end
    end else if (a == 3'd1) begin
      if (d == KB) mB = 1; else begin mA = 0; mB = 0; end
    end else if (a == 3'd2 && !wasLocked) begin
      mVec = {d[31:10], 10'b0};
    end
  endtask

  task automatic doWrite(logic [2:0] a, logic [31:0] d, string req);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    wrEn = 1'b0;
    chk(req, {31'b0, locked}, {31'b0, expLocked()});
    chk(req, bootAddr, mVec);
  endtask

  task automatic doRead(logic [2:0] a, string req);
    @(negedge clk);
    regAddr = a; wrEn = 1'b0;
    #1;
    chk(req, rdData, expRead(a));
  endtask

  initial begin
    mA = 0; mB = 0; mVec = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 locked after reset", {31'b0, locked}, 32'd1);
    chk("R1 vector after reset", bootAddr, 32'h0);
    rstN = 1'b1;

    // Locked write is ignored
    doWrite(3'd2, 32'hDEAD_BEEF, "R2 locked vector write");
    doRead(3'd2, "R2 vector readback");

    // Unlock A then B
    doWrite(3'd0, KA, "R3 key A only");
    doWrite(3'd1, KB, "R3 unlock A then B");
    doWrite(3'd2, 32'hFFFF_FFFF, "R5 all-ones vector");
    doRead(3'd2, "R5 low bits read zero");
    doRead(3'd0, "R6 key A reads zero");
    doRead(3'd1, "R6 key B reads zero");
    doWrite(3'd5, 32'h1234_5678, "R6 unmapped write");
    doRead(3'd5, "R6 unmapped reads zero");
    doWrite(3'd2, 32'h1180_03FF, "R7 second vector write stays unlocked");
    doWrite(3'd0, KA, "R7 repeated key stays unlocked");

    // Wrong key relocks and discards both
    doWrite(3'd1, 32'h95A4_F1E1, "R4 bad key B relocks");
    doWrite(3'd1, KB, "R4 single key after relock");
    doWrite(3'd2, 32'hAAAA_A000, "R4 vector still protected");

    // Unlock B then A, then bad A after one good key
    doWrite(3'd0, KA, "R3 unlock B then A");
    doWrite(3'd2, 32'h0000_0400, "R5 smallest nonzero vector");
    doWrite(3'd0, 32'h0, "R4 bad key A relocks");
    doWrite(3'd0, KA, "R4 A alone after relock");
    doWrite(3'd0, 32'h83E7_0B12, "R4 bad A clears progress");
    doWrite(3'd1, KB, "R4 B alone after relock");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 10;
      logic [2:0] a = 3'($urandom % 8);
      logic [31:0] d = $urandom;
      if (r < 2) begin a = 3'd0; d = KA; end
      else if (r < 4) begin a = 3'd1; d = KB; end
      else if (r < 6) a = 3'd2;
      if ($urandom % 4 == 0) doRead(a, "R2 R6 random read");
      else doWrite(a, d, "R3 R4 R5 R7 random write");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule